// File: doc/BRIEF.md
# Voltage-to-Frequency Converter Trip Counter with Dead-Time Correction

This block is the digital half of an integrating voltage-to-frequency converter. An external integrator ramps up at a rate set by the analog input, and a comparator raises a trip line when the ramp reaches its threshold. The block brings that asynchronous trip line into the clock domain and finds its rising edge. For each accepted trip it drives a discharge pulse of a programmed number of clock cycles, which shorts the integrator capacitor, and it adds one to a trip counter.

Trips are counted over a gate window whose length in clock cycles can be programmed. No integration takes place while the capacitor is shorted, so the raw count reads low. At the end of each window the block reports the raw count together with a corrected count. The corrected count adds back the trips estimated as lost during the dead time: raw squared, times the dead time, divided by the gate length. This correction runs through a short multiply stage and a bit-serial divider. When it completes, the block raises a one-cycle result strobe.

Top module: `vfc_count_core`

## Requirements
- R1: While reset is asserted and after its release, until the first result strobe, rawCount, corrCount, overflow, resultValid and discharge are all 0.
- R2: The trip input passes through a two-stage synchronizer followed by a rising-edge detector. A trip held high for many cycles is counted exactly once.
- R3: An accepted trip drives discharge high for exactly deadLen consecutive cycles. A deadLen of 0 is treated as 1.
- R4: A rising trip edge that is detected while discharge is high is ignored. It is not counted and does not extend the pulse.
- R5: The gate window lasts max(gateLen, 2*CNT_W+DEAD_W+4) cycles. resultValid is a one-cycle pulse, issued once per window.
- R6: rawCount is the number of trips accepted in the last complete window. rawCount, corrCount and overflow hold their values between result strobes.
- R7: corrCount = min(raw + floor(raw*raw*D/G), 2^CNT_W-1). D is the effective dead time and G is the effective gate length, both captured at the end of the window.
- R8: The trip counter saturates at 2^CNT_W-1. overflow is 1 for a window in which a trip arrived while the counter was already at that maximum, and 0 for a window without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tripAsync | input | 1 | Comparator trip line, asynchronous |
| gateLen | input | GATE_W | Gate window length in cycles |
| deadLen | input | DEAD_W | Discharge pulse width in cycles |
| discharge | output | 1 | Drives the integrator shorting switch |
| rawCount | output | CNT_W | Trips accepted in the last window |
| corrCount | output | CNT_W | Dead-time corrected count |
| overflow | output | 1 | Raw counter exceeded its range in the last window |
| resultValid | output | 1 | One-cycle strobe when new results are present |

## Verification
The discharge-width checks assume that deadLen only changes while no discharge pulse is in flight. The checks on result values assume that a window is far longer than the correction pipeline, which the minimum gate length guarantees. The bench applies each new configuration and then lets two windows pass before it injects trips, so each measured window runs entirely under one setting. Trip pulses are driven on falling clock edges and are always kept high and low for at least one full cycle, so the synchronizer sees every edge.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

  // Strobes from the sequencing control into the counting datapath
  typedef struct packed {
    logic acceptTrip;
    logic winEnd;
    logic mulSquare;
    logic mulDead;
    logic divStep;
    logic publish;
  } vfcStrobe_t;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_SQUARE,
    CS_DEAD,
    CS_DIV,
    CS_PUB
  } corrState_e;

endpackage

// File: rtl/vfc_ctrl.sv
module vfc_ctrl
  import vfc_pkg::*;
#(
  parameter int GATE_W = 20,
  parameter int DEAD_W = 8,
  parameter int NUM_W  = 40,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tripAsync,
  input  logic [GATE_W-1:0] gateLen,
  input  logic [DEAD_W-1:0] deadLen,
  output logic              discharge,
  output logic [GATE_W-1:0] gateEff,
  output logic [DEAD_W-1:0] deadEff,
  output vfcStrobe_t        strobe
);

  localparam int MIN_GATE = NUM_W + 4;
  localparam int STEP_W   = $clog2(NUM_W + 1);
  localparam logic [GATE_W-1:0] MIN_GATE_V = GATE_W'(MIN_GATE);
  localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(NUM_W - 1);

  // Synchronizer plus one extra stage for edge detection
  logic [SYNC_N:0]   syncQ;
  logic              tripRise;
  logic              acceptTrip;
  logic [DEAD_W-1:0] dchCnt;
  logic [GATE_W-1:0] gateCnt;
  logic              winEnd;
  corrState_e        state;
  logic [STEP_W-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_N-1:0], tripAsync};
  end

  assign tripRise   = syncQ[SYNC_N-1] & ~syncQ[SYNC_N];
  assign deadEff    = (deadLen == '0) ? DEAD_W'(1) : deadLen;
  assign acceptTrip = tripRise && (dchCnt == '0);
  assign discharge  = (dchCnt != '0);

  // Discharge pulse timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dchCnt <= '0;
    else if (acceptTrip)     dchCnt <= deadEff;
    else if (dchCnt != '0)   dchCnt <= dchCnt - 1'b1;
  end

  // Gate window timer
  assign gateEff = (gateLen < MIN_GATE_V) ? MIN_GATE_V : gateLen;
  assign winEnd  = (gateCnt >= gateEff - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       gateCnt <= '0;
    else if (winEnd) gateCnt <= '0;
    else             gateCnt <= gateCnt + 1'b1;
  end

  // Correction sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= CS_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (state)
        CS_IDLE:   if (winEnd) state <= CS_SQUARE;
        CS_SQUARE: state <= CS_DEAD;
        CS_DEAD: begin
          state   <= CS_DIV;
          stepCnt <= '0;
        end
        CS_DIV: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) state <= CS_PUB;
        end
        CS_PUB:    state <= CS_IDLE;
        default:   state <= CS_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.acceptTrip = acceptTrip;
    strobe.winEnd     = winEnd;
    strobe.mulSquare  = (state == CS_SQUARE);
    strobe.mulDead    = (state == CS_DEAD);
    strobe.divStep    = (state == CS_DIV);
    strobe.publish    = (state == CS_PUB);
  end

endmodule

// File: rtl/vfc_dpath.sv
module vfc_dpath
  import vfc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int GATE_W = 20,
  parameter int DEAD_W = 8,
  parameter int NUM_W  = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  vfcStrobe_t        strobe,
  input  logic [GATE_W-1:0] gateEff,
  input  logic [DEAD_W-1:0] deadEff,
  output logic [CNT_W-1:0]  rawCount,
  output logic [CNT_W-1:0]  corrCount,
  output logic              overflow,
  output logic              resultValid
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int SQ_W = 2 * CNT_W;

  logic [CNT_W-1:0]  tripCnt, cntNext;
  logic              ovfRun, ovfNext;
  logic [CNT_W-1:0]  snapRaw;
  logic              snapOvf;
  logic [GATE_W-1:0] snapGate;
  logic [DEAD_W-1:0] snapDead;
  logic [SQ_W-1:0]   sqReg;
  logic [NUM_W-1:0]  numQ;
  logic [GATE_W-1:0] remReg;
  logic [GATE_W:0]   remShift;
  logic              remFits;
  logic [NUM_W:0]    corrSum;
  logic [CNT_W-1:0]  corrSat;

  // Saturating trip counter
  always_comb begin
    cntNext = tripCnt;
    ovfNext = ovfRun;
    if (strobe.acceptTrip) begin
      if (tripCnt == CNT_MAX) ovfNext = 1'b1;
      else                    cntNext = tripCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripCnt  <= '0;
      ovfRun   <= 1'b0;
      snapRaw  <= '0;
      snapOvf  <= 1'b0;
      snapGate <= '0;
      snapDead <= '0;
    end else if (strobe.winEnd) begin
      snapRaw  <= cntNext;
      snapOvf  <= ovfNext;
      snapGate <= gateEff;
      snapDead <= deadEff;
      tripCnt  <= '0;
      ovfRun   <= 1'b0;
    end else begin
      tripCnt  <= cntNext;
      ovfRun   <= ovfNext;
    end
  end

  // Two multiply stages and a restoring bit-serial divider
  assign remShift = {remReg, numQ[NUM_W-1]};
  assign remFits  = (remShift >= {1'b0, snapGate});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqReg  <= '0;
      numQ   <= '0;
      remReg <= '0;
    end else if (strobe.mulSquare) begin
      sqReg <= {{CNT_W{1'b0}}, snapRaw} * {{CNT_W{1'b0}}, snapRaw};
    end else if (strobe.mulDead) begin
      numQ   <= {{DEAD_W{1'b0}}, sqReg} * {{SQ_W{1'b0}}, snapDead};
      remReg <= '0;
    end else if (strobe.divStep) begin
      if (remFits) begin
        remReg <= GATE_W'(remShift - {1'b0, snapGate});
        numQ   <= {numQ[NUM_W-2:0], 1'b1};
      end else begin
        remReg <= remShift[GATE_W-1:0];
        numQ   <= {numQ[NUM_W-2:0], 1'b0};
      end
    end
  end

  assign corrSum = {1'b0, numQ} + {{(NUM_W + 1 - CNT_W){1'b0}}, snapRaw};
  assign corrSat = (corrSum > {{(NUM_W + 1 - CNT_W){1'b0}}, CNT_MAX})
                   ? CNT_MAX : corrSum[CNT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawCount    <= '0;
      corrCount   <= '0;
      overflow    <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strobe.publish;
      if (strobe.publish) begin
        rawCount  <= snapRaw;
        corrCount <= corrSat;
        overflow  <= snapOvf;
      end
    end
  end

endmodule

// File: rtl/vfc_count_core.sv
module vfc_count_core
  import vfc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int GATE_W = 20,
  parameter int DEAD_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tripAsync,
  input  logic [GATE_W-1:0] gateLen,
  input  logic [DEAD_W-1:0] deadLen,
  output logic              discharge,
  output logic [CNT_W-1:0]  rawCount,
  output logic [CNT_W-1:0]  corrCount,
  output logic              overflow,
  output logic              resultValid
);

  localparam int NUM_W = 2 * CNT_W + DEAD_W;

  vfcStrobe_t        strobe;
  logic [GATE_W-1:0] gateEff;
  logic [DEAD_W-1:0] deadEff;

  vfc_ctrl #(
    .GATE_W(GATE_W), .DEAD_W(DEAD_W), .NUM_W(NUM_W), .SYNC_N(SYNC_N)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .tripAsync(tripAsync),
    .gateLen(gateLen), .deadLen(deadLen),
    .discharge(discharge), .gateEff(gateEff), .deadEff(deadEff),
    .strobe(strobe)
  );

  vfc_dpath #(
    .CNT_W(CNT_W), .GATE_W(GATE_W), .DEAD_W(DEAD_W), .NUM_W(NUM_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .gateEff(gateEff), .deadEff(deadEff),
    .rawCount(rawCount), .corrCount(corrCount),
    .overflow(overflow), .resultValid(resultValid)
  );

endmodule

// File: rtl/vfc_count_core_chk.sv
module vfc_count_core_chk #(
  parameter int CNT_W  = 16,
  parameter int GATE_W = 20,
  parameter int DEAD_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DEAD_W-1:0] deadLen,
  input logic              discharge,
  input logic [CNT_W-1:0]  rawCount,
  input logic [CNT_W-1:0]  corrCount,
  input logic              overflow,
  input logic              resultValid
);

  localparam int MIN_GATE = 2 * CNT_W + DEAD_W + 4;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DEAD_W:0]   dchRun;
  logic [DEAD_W:0]   deadExp;
  logic [GATE_W:0]   gapCnt;
  logic              seenValid;

  assign deadExp = (deadLen == '0) ? (DEAD_W+1)'(1) : {1'b0, deadLen};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dchRun    <= '0;
      gapCnt    <= '0;
      seenValid <= 1'b0;
    end else begin
      dchRun <= discharge ? dchRun + 1'b1 : '0;
      if (resultValid) begin
        gapCnt    <= '0;
        seenValid <= 1'b1;
      end else if (gapCnt != {(GATE_W+1){1'b1}}) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  // R3: a pulse never runs longer than the programmed width
  p_dch_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    discharge |-> (dchRun < deadExp));

  // R3: a pulse that ends has run for exactly the programmed width
  p_dch_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(discharge) |-> (dchRun == deadExp));

  // R5: strobe lasts one cycle
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R5: strobes are spaced by at least the minimum window
  p_valid_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && seenValid) |-> (gapCnt + 1'b1 >= (GATE_W+1)'(MIN_GATE)));

  // R6: results hold between strobes
  p_raw_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> ($stable(rawCount) && $stable(corrCount) && $stable(overflow)));

  // R7: correction never lowers the count
  p_corr_ge_raw_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (corrCount >= rawCount));

  // R8: overflow only with a saturated raw count
  p_ovf_sat_r8: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && overflow) |-> (rawCount == CNT_MAX));

endmodule

bind vfc_count_core vfc_count_core_chk #(
  .CNT_W(CNT_W), .GATE_W(GATE_W), .DEAD_W(DEAD_W)
) chk_i (
  .clk(clk), .rstN(rstN), .deadLen(deadLen), .discharge(discharge),
  .rawCount(rawCount), .corrCount(corrCount), .overflow(overflow),
  .resultValid(resultValid)
);

// File: tb/vfc_count_core_tb_top.sv
module vfc_count_core_tb_top;

  localparam int CNT_W  = 10;
  localparam int GATE_W = 16;
  localparam int DEAD_W = 6;
  localparam int MIN_GATE = 2 * CNT_W + DEAD_W + 4;
  localparam int CNT_MAX  = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tripDrive = 1'b0;
  logic              tripModel = 1'b0;
  logic              useModel = 1'b0;
  logic              tripAsync;
  logic [GATE_W-1:0] gateLen = 16'd1000;
  logic [DEAD_W-1:0] deadLen = 6'd4;
  logic              discharge;
  logic [CNT_W-1:0]  rawCount;
  logic [CNT_W-1:0]  corrCount;
  logic              overflow;
  logic              resultValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int acc    = 0;

  always #10 clk = ~clk;

  assign tripAsync = useModel ? tripModel : tripDrive;

  vfc_count_core #(
    .CNT_W(CNT_W), .GATE_W(GATE_W), .DEAD_W(DEAD_W)
  ) dut_i (
    .clk(clk), .rstN(rstN), .tripAsync(tripAsync),
    .gateLen(gateLen), .deadLen(deadLen), .discharge(discharge),
    .rawCount(rawCount), .corrCount(corrCount), .overflow(overflow),
    .resultValid(resultValid)
  );

  // Behavioural integrator and comparator
  always @(negedge clk) begin
    if (useModel) begin
      if (discharge) acc = 0;
      else           acc = acc + 5;
      tripModel = (acc >= 100);
    end else begin
      acc = 0;
      tripModel = 1'b0;
    end
  end

  function automatic int expCorr(int n, int d, int g);
    longint s;
    s = longint'(n) + (longint'(n) * n * d) / g;
    return (s > CNT_MAX) ? CNT_MAX : int'(s);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitValid();
    do @(negedge clk); while (!resultValid);
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk);
    tripDrive = 1'b1;
    repeat (hi) @(negedge clk);
    tripDrive = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic configure(input int g, input int d);
    @(negedge clk);
    gateLen = GATE_W'(g);
    deadLen = DEAD_W'(d);
    waitValid();
    waitValid();
  endtask

  task automatic measureWidth(output int w);
    int guard = 0;
    w = 0;
    while (!discharge && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    while (discharge) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(rawCount == 0 && corrCount == 0, "R1 counts", rawCount, 0);
    check(!overflow && !resultValid && !discharge, "R1 flags",
          {overflow, resultValid, discharge}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(rawCount == 0 && !discharge && !resultValid, "R1 after release", rawCount, 0);
  endtask

  task automatic t_basic();
    configure(1000, 10);
    for (int i = 0; i < 20; i++) pulse(2, 12);
    waitValid();
    check(rawCount == 20, "R6 raw basic", rawCount, 20);
    check(corrCount == expCorr(20, 10, 1000), "R7 corr basic", corrCount, expCorr(20, 10, 1000));
    check(!overflow, "R8 no overflow", overflow, 0);
    waitValid();
    check(rawCount == 0 && corrCount == 0, "R6 empty window", rawCount, 0);
  endtask

  task automatic t_width();
    int w;
    configure(400, 7);
    pulse(2, 2);
    measureWidth(w);
    check(w == 7, "R3 width 7", w, 7);
    configure(400, 0);
    pulse(2, 2);
    measureWidth(w);
    check(w == 1, "R3 width zero->1", w, 1);
  endtask

  task automatic t_level();
    configure(1000, 4);
    pulse(60, 10);
    waitValid();
    check(rawCount == 1, "R2 held level once", rawCount, 1);
  endtask

  task automatic t_ignore();
    configure(1000, 20);
    pulse(2, 5);
    pulse(2, 50);
    pulse(2, 50);
    waitValid();
    check(rawCount == 2, "R4 trip during discharge", rawCount, 2);
  endtask

  task automatic t_gate();
    int n;
    configure(100, 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!resultValid);
    check(n == 100, "R5 window 100", n, 100);
    configure(5, 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!resultValid);
    check(n == MIN_GATE, "R5 window clamp", n, MIN_GATE);
  endtask

  task automatic t_ovf();
    configure(3000, 1);
    for (int i = 0; i < 1100; i++) pulse(1, 1);
    waitValid();
    check(rawCount == CNT_MAX, "R8 raw saturates", rawCount, CNT_MAX);
    check(overflow, "R8 overflow set", overflow, 1);
    check(corrCount == CNT_MAX, "R7 corr at max", corrCount, CNT_MAX);
    for (int i = 0; i < 5; i++) pulse(2, 6);
    waitValid();
    check(rawCount == 5, "R8 count after overflow", rawCount, 5);
    check(!overflow, "R8 overflow clears", overflow, 0);
  endtask

  task automatic t_corrSat();
    configure(4000, 2);
    for (int i = 0; i < 900; i++) pulse(2, 2);
    waitValid();
    check(rawCount == 900, "R6 raw 900", rawCount, 900);
    check(corrCount == expCorr(900, 2, 4000), "R7 corr saturates", corrCount, expCorr(900, 2, 4000));
    check(!overflow, "R8 no raw overflow", overflow, 0);
  endtask

  task automatic t_model();
    configure(2000, 3);
    useModel = 1'b1;
    waitValid();
    waitValid();
    check(rawCount > 0, "R6 model trips", rawCount, 1);
    check(corrCount == expCorr(rawCount, 3, 2000), "R7 model corr",
          corrCount, expCorr(rawCount, 3, 2000));
    useModel = 1'b0;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_width();
    t_level();
    t_ignore();
    t_gate();
    t_ovf();
    t_corrSat();
    t_model();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule